// File: doc/BRIEF.md
# Glitch-Free Output Clock Stop Controller

This block sits between the clock generators of a clock synthesizer and its output pins. It takes a set of free-running source clocks and produces the gated output clocks together with a drive-enable flag for each output line. Three things can silence an output: a power-down request from an active-low pin, a stop request for the bus-clock group (from an active-low pin or from a software bit), and a per-output enable bit. Every stop and every restart happens while the affected clock is low, so no output ever shows a high pulse shorter than its source's high time.

Power-down is accepted only after the pin has been seen low on two successive rising edges of the CPU complement clock. Single-ended outputs then park low. The differential CPU pairs park with the true line high and the complement undriven, and a per-pair bit can float both lines instead. The SRC pair parks true-high/complement-low, and separate bits choose whether it floats when power-down or a bus stop parks it. One single-ended output comes from a glitch-free two-input mux that picks between the 66 MHz source and a 48 MHz source.

Top module: `clkstop_ctrl`

## Requirements
- R1: Power-down becomes active only when `pd_n` has been sampled low on two successive rising edges of the CPU complement clock (falling edges of `cpu_clk`). A low that spans only one such edge has no effect, and power-down clears as soon as `pd_n` is sampled high.
- R2: While power-down is active, every single-ended output (bus, free-running bus, 66 MHz, selectable, 48 MHz USB, 48 MHz DOT, reference) is held low and stays driven if its enable bit is 1. It stops at a falling edge of its source.
- R3: In power-down each CPU pair drives its true line high and leaves its complement undriven (`cpu_c_oe` = 0). When the pair's bit in `cpu_pd_tri` is 1, `cpu_t_oe` is 0 as well.
- R4: In power-down the SRC pair parks with `src_t` = 1 and `src_c` = 0. Both lines are driven when `src_pd_tri` = 0 and undriven when it is 1.
- R5: The bus stop pin `pci_stop_n` = 0 halts all `pci_out` bits low. It halts a `pcif_out` bit only when the matching `pcif_stp_en` bit is 1, and it halts the SRC pair only when `src_stp_en` = 1. CPU, 66 MHz, selectable, USB, DOT and reference outputs keep running.
- R6: `sw_stop` = 1 halts the same set of outputs as the stop pin does, with the same stop-enable bits.
- R7: While the SRC pair is parked by a bus stop (and power-down is off), both its lines are driven when `src_stp_tri` = 0 and undriven when it is 1.
- R8: An enable bit of 0 clears the drive flag of that output (both flags for a pair). The drive flags of all other outputs stay set.
- R9: `vch_sel` = 0 routes the 66 MHz source to `vch_out` and `vch_sel` = 1 routes the 48 MHz USB source to it. At most one source is ever connected.
- R10: When a stop or a power-down is released, each output restarts on a rising edge of its source. No output ever shows a high pulse shorter than its source's high time.
- R11: While `rst_n` is low, all single-ended outputs are low, each pair shows true = 1 and complement = 0, and the CPU complement lines are undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_clk | input | 1 | CPU source clock (true phase) |
| src_clk | input | 1 | SRC source clock (true phase) |
| v66_clk | input | 1 | 66 MHz source clock |
| pci_clk | input | 1 | 33 MHz bus source clock |
| usb_clk | input | 1 | 48 MHz USB source clock, also the alternate source of the selectable output |
| dot_clk | input | 1 | 48 MHz DOT source clock |
| ref_clk | input | 1 | Reference source clock |
| pd_n | input | 1 | Power-down request, active low |
| pci_stop_n | input | 1 | Bus-clock stop request, active low |
| sw_stop | input | 1 | Software bus-clock stop request |
| cpu_en | input | N_CPU | Enable bit per CPU pair |
| cpu_pd_tri | input | N_CPU | Float both CPU lines in power-down |
| src_en | input | 1 | SRC pair enable |
| src_pd_tri | input | 1 | Float SRC pair in power-down |
| src_stp_en | input | 1 | SRC pair obeys bus stop |
| src_stp_tri | input | 1 | Float SRC pair when parked by bus stop |
| pci_en | input | N_PCI | Enable bit per bus output |
| pcif_en | input | N_PCIF | Enable bit per free-running bus output |
| pcif_stp_en | input | N_PCIF | Free-running bus output obeys bus stop |
| v66_en | input | N_V66 | Enable bit per 66 MHz output |
| vch_en | input | 1 | Selectable output enable |
| vch_sel | input | 1 | Selectable output source: 0 = 66 MHz, 1 = 48 MHz |
| usb_en | input | 1 | USB output enable |
| dot_en | input | 1 | DOT output enable |
| ref_en | input | N_REF | Enable bit per reference output |
| cpu_t | output | N_CPU | CPU true lines |
| cpu_t_oe | output | N_CPU | CPU true drive flags |
| cpu_c | output | N_CPU | CPU complement lines |
| cpu_c_oe | output | N_CPU | CPU complement drive flags |
| src_t | output | 1 | SRC true line |
| src_t_oe | output | 1 | SRC true drive flag |
| src_c | output | 1 | SRC complement line |
| src_c_oe | output | 1 | SRC complement drive flag |
| pci_out | output | N_PCI | Stoppable bus clocks |
| pci_oe | output | N_PCI | Bus clock drive flags |
| pcif_out | output | N_PCIF | Free-running bus clocks |
| pcif_oe | output | N_PCIF | Free-running bus clock drive flags |
| v66_out | output | N_V66 | 66 MHz clocks |
| v66_oe | output | N_V66 | 66 MHz drive flags |
| vch_out | output | 1 | Selectable 66/48 MHz clock |
| vch_oe | output | 1 | Selectable clock drive flag |
| usb_out | output | 1 | USB 48 MHz clock |
| usb_oe | output | 1 | USB drive flag |
| dot_out | output | 1 | DOT 48 MHz clock |
| dot_oe | output | 1 | DOT drive flag |
| ref_out | output | N_REF | Reference clocks |
| ref_oe | output | N_REF | Reference drive flags |

## Verification
The hardest case to reach is a power-down pin low that spans exactly one falling edge of the CPU source: the qualifier must see it once and ignore it. The stimulus waits for a falling edge of `cpu_clk`, pulls `pd_n` low shortly after and raises it again just after the next falling edge. It then confirms at the ports that every output keeps toggling. A second hard case is a short high pulse during a stop, restart or mux switch. A background monitor samples all 29 output lines between edges and measures every high run against its source's high time through all the scenarios, including the switch of the selectable output in both directions.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

  // Flop stages that carry a stop request into an output clock's domain.
  localparam int SYNC_DEPTH_DEF = 2;
  // Successive complement-clock edges with the pin low that qualify power-down.
  localparam int QUAL_EDGES_DEF = 2;

  // A stop is wanted for power-down, or for a bus stop on a stoppable output.
  function automatic logic stop_request(input logic pd, input logic bus_stop,
                                        input logic obeys_stop);
    return pd | (bus_stop & obeys_stop);
  endfunction

  // A line that parks driven unless its float bit is set.
  function automatic logic park_drive(input logic en, input logic run,
                                      input logic float_when_parked);
    return en & (run | ~float_when_parked);
  endfunction

  // One side of the source mux may claim the output only when the other is off.
  function automatic logic mux_claim(input logic wanted, input logic other_on);
    return wanted & ~other_on;
  endfunction

endpackage

// File: rtl/clkstop_pd_qual.sv
`timescale 1ns/1ps
module clkstop_pd_qual #(
  parameter int QUAL_EDGES = clkstop_pkg::QUAL_EDGES_DEF
) (
  input  logic rst_n,
  input  logic cpu_clk,
  input  logic pd_n,
  output logic pd_active
);
  logic                  cpu_clk_n;
  logic [QUAL_EDGES-1:0] low_hist;

  assign cpu_clk_n = ~cpu_clk;

  // Sample the pin on rising edges of the complement clock.
  always_ff @(posedge cpu_clk_n or negedge rst_n) begin
    if (!rst_n) low_hist <= '0;
    else        low_hist <= {low_hist[QUAL_EDGES-2:0], ~pd_n};
  end

  assign pd_active = &low_hist;
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate #(
  parameter int SYNC_DEPTH = clkstop_pkg::SYNC_DEPTH_DEF
) (
  input  logic rst_n,
  input  logic clk,
  input  logic stop,
  output logic running
);
  logic [SYNC_DEPTH-1:0] stop_sync;
  logic                  run_q;

  // Bring the asynchronous stop request into this clock's domain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_sync <= '1;
    else        stop_sync <= {stop_sync[SYNC_DEPTH-2:0], stop};
  end

  // Run state changes only at a falling edge, i.e. while the clock is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= ~stop_sync[SYNC_DEPTH-1];
  end

  assign running = run_q;
endmodule

// File: rtl/clkstop_pair.sv
`timescale 1ns/1ps
module clkstop_pair #(
  parameter int SYNC_DEPTH  = clkstop_pkg::SYNC_DEPTH_DEF,
  parameter bit COMP_FLOATS = 1'b1
) (
  input  logic rst_n,
  input  logic clk,
  input  logic stop,
  input  logic en,
  input  logic float_park,
  output logic t,
  output logic t_oe,
  output logic c,
  output logic c_oe,
  output logic running
);
  import clkstop_pkg::*;

  logic clk_n;
  logic run;
  logic c_gated;

  assign clk_n = ~clk;

  // Gate the complement phase: it parks low at its own falling edge,
  // which leaves the true line parked high.
  clkstop_gate #(.SYNC_DEPTH(SYNC_DEPTH)) u_gate (
    .rst_n   (rst_n),
    .clk     (clk_n),
    .stop    (stop),
    .running (run)
  );

  assign c_gated = clk_n & run;
  assign c       = c_gated;
  assign t       = ~c_gated;
  assign t_oe    = park_drive(en, run, float_park);
  assign running = run;

  generate
    if (COMP_FLOATS) begin : g_comp_float
      assign c_oe = en & run;
    end else begin : g_comp_driven
      assign c_oe = park_drive(en, run, float_park);
    end
  endgenerate
endmodule

// File: rtl/clkstop_mux.sv
`timescale 1ns/1ps
module clkstop_mux (
  input  logic rst_n,
  input  logic clk_a,
  input  logic clk_b,
  input  logic sel_b,
  output logic clk_out,
  output logic a_on,
  output logic b_on
);
  import clkstop_pkg::*;

  logic a_req, b_req;
  logic a_on_q, b_on_q;

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) a_req <= 1'b0;
    else        a_req <= mux_claim(~sel_b, b_on_q);
  end

  always_ff @(negedge clk_a or negedge rst_n) begin
    if (!rst_n) a_on_q <= 1'b0;
    else        a_on_q <= a_req;
  end

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) b_req <= 1'b0;
    else        b_req <= mux_claim(sel_b, a_on_q);
  end

  always_ff @(negedge clk_b or negedge rst_n) begin
    if (!rst_n) b_on_q <= 1'b0;
    else        b_on_q <= b_req;
  end

  assign clk_out = (clk_a & a_on_q) | (clk_b & b_on_q);
  assign a_on    = a_on_q;
  assign b_on    = b_on_q;
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl #(
  parameter int N_CPU      = 4,
  parameter int N_PCI      = 7,
  parameter int N_PCIF     = 3,
  parameter int N_V66      = 4,
  parameter int N_REF      = 2,
  parameter int SYNC_DEPTH = clkstop_pkg::SYNC_DEPTH_DEF,
  parameter int QUAL_EDGES = clkstop_pkg::QUAL_EDGES_DEF
) (
  input  logic              rst_n,
  input  logic              cpu_clk,
  input  logic              src_clk,
  input  logic              v66_clk,
  input  logic              pci_clk,
  input  logic              usb_clk,
  input  logic              dot_clk,
  input  logic              ref_clk,
  input  logic              pd_n,
  input  logic              pci_stop_n,
  input  logic              sw_stop,
  input  logic [N_CPU-1:0]  cpu_en,
  input  logic [N_CPU-1:0]  cpu_pd_tri,
  input  logic              src_en,
  input  logic              src_pd_tri,
  input  logic              src_stp_en,
  input  logic              src_stp_tri,
  input  logic [N_PCI-1:0]  pci_en,
  input  logic [N_PCIF-1:0] pcif_en,
  input  logic [N_PCIF-1:0] pcif_stp_en,
  input  logic [N_V66-1:0]  v66_en,
  input  logic              vch_en,
  input  logic              vch_sel,
  input  logic              usb_en,
  input  logic              dot_en,
  input  logic [N_REF-1:0]  ref_en,
  output logic [N_CPU-1:0]  cpu_t,
  output logic [N_CPU-1:0]  cpu_t_oe,
  output logic [N_CPU-1:0]  cpu_c,
  output logic [N_CPU-1:0]  cpu_c_oe,
  output logic              src_t,
  output logic              src_t_oe,
  output logic              src_c,
  output logic              src_c_oe,
  output logic [N_PCI-1:0]  pci_out,
  output logic [N_PCI-1:0]  pci_oe,
  output logic [N_PCIF-1:0] pcif_out,
  output logic [N_PCIF-1:0] pcif_oe,
  output logic [N_V66-1:0]  v66_out,
  output logic [N_V66-1:0]  v66_oe,
  output logic              vch_out,
  output logic              vch_oe,
  output logic              usb_out,
  output logic              usb_oe,
  output logic              dot_out,
  output logic              dot_oe,
  output logic [N_REF-1:0]  ref_out,
  output logic [N_REF-1:0]  ref_oe
);
  import clkstop_pkg::*;

  // Named internal events, also observed by the bound checker.
  logic              pd_active;
  logic              bus_stop;
  logic              src_float_sel;
  logic [N_CPU-1:0]  cpu_run;
  logic              src_run;
  logic [N_PCI-1:0]  pci_run;
  logic [N_PCIF-1:0] pcif_run;
  logic [N_V66-1:0]  v66_run;
  logic [N_REF-1:0]  ref_run;
  logic              vch_run, usb_run, dot_run;
  logic              vch_src_clk, vch_a_on, vch_b_on;

  assign bus_stop = ~pci_stop_n | sw_stop;

  clkstop_pd_qual #(.QUAL_EDGES(QUAL_EDGES)) u_qual (
    .rst_n     (rst_n),
    .cpu_clk   (cpu_clk),
    .pd_n      (pd_n),
    .pd_active (pd_active)
  );

  // CPU pairs: stopped by power-down only, complement floats when parked.
  generate
    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
      clkstop_pair #(.SYNC_DEPTH(SYNC_DEPTH), .COMP_FLOATS(1'b1)) u_pair (
        .rst_n      (rst_n),
        .clk        (cpu_clk),
        .stop       (pd_active),
        .en         (cpu_en[i]),
        .float_park (cpu_pd_tri[i]),
        .t          (cpu_t[i]),
        .t_oe       (cpu_t_oe[i]),
        .c          (cpu_c[i]),
        .c_oe       (cpu_c_oe[i]),
        .running    (cpu_run[i])
      );
    end
  endgenerate

  // SRC pair: stoppable by bus stop on request, float choice by cause.
  assign src_float_sel = pd_active ? src_pd_tri : src_stp_tri;

  clkstop_pair #(.SYNC_DEPTH(SYNC_DEPTH), .COMP_FLOATS(1'b0)) u_src (
    .rst_n      (rst_n),
    .clk        (src_clk),
    .stop       (stop_request(pd_active, bus_stop, src_stp_en)),
    .en         (src_en),
    .float_park (src_float_sel),
    .t          (src_t),
    .t_oe       (src_t_oe),
    .c          (src_c),
    .c_oe       (src_c_oe),
    .running    (src_run)
  );

  // Bus clocks: always obey the bus stop.
  generate
    for (genvar i = 0; i < N_PCI; i++) begin : g_pci
      clkstop_gate #(.SYNC_DEPTH(SYNC_DEPTH)) u_gate (
        .rst_n   (rst_n),
        .clk     (pci_clk),
        .stop    (stop_request(pd_active, bus_stop, 1'b1)),
        .running (pci_run[i])
      );
      assign pci_out[i] = pci_clk & pci_run[i];
    end

    // Free-running bus clocks: obey the bus stop only on request.
    for (genvar i = 0; i < N_PCIF; i++) begin : g_pcif
      clkstop_gate #(.SYNC_DEPTH(SYNC_DEPTH)) u_gate (
        .rst_n   (rst_n),
        .clk     (pci_clk),
        .stop    (stop_request(pd_active, bus_stop, pcif_stp_en[i])),
        .running (pcif_run[i])
      );
      assign pcif_out[i] = pci_clk & pcif_run[i];
    end

    for (genvar i = 0; i < N_V66; i++) begin : g_v66
      clkstop_gate #(.SYNC_DEPTH(SYNC_DEPTH)) u_gate (
        .rst_n   (rst_n),
        .clk     (v66_clk),
        .stop    (pd_active),
        .running (v66_run[i])
      );
      assign v66_out[i] = v66_clk & v66_run[i];
    end

    for (genvar i = 0; i < N_REF; i++) begin : g_ref
      clkstop_gate #(.SYNC_DEPTH(SYNC_DEPTH)) u_gate (
        .rst_n   (rst_n),
        .clk     (ref_clk),
        .stop    (pd_active),
        .running (ref_run[i])
      );
      assign ref_out[i] = ref_clk & ref_run[i];
    end
  endgenerate

  // Selectable output: glitch-free source mux, then the power-down gate.
  clkstop_mux u_vch_mux (
    .rst_n   (rst_n),
    .clk_a   (v66_clk),
    .clk_b   (usb_clk),
    .sel_b   (vch_sel),
    .clk_out (vch_src_clk),
    .a_on    (vch_a_on),
    .b_on    (vch_b_on)
  );

  clkstop_gate #(.SYNC_DEPTH(SYNC_DEPTH)) u_vch_gate (
    .rst_n   (rst_n),
    .clk     (vch_src_clk),
    .stop    (pd_active),
    .running (vch_run)
  );
  assign vch_out = vch_src_clk & vch_run;

  clkstop_gate #(.SYNC_DEPTH(SYNC_DEPTH)) u_usb_gate (
    .rst_n   (rst_n),
    .clk     (usb_clk),
    .stop    (pd_active),
    .running (usb_run)
  );
  assign usb_out = usb_clk & usb_run;

  clkstop_gate #(.SYNC_DEPTH(SYNC_DEPTH)) u_dot_gate (
    .rst_n   (rst_n),
    .clk     (dot_clk),
    .stop    (pd_active),
    .running (dot_run)
  );
  assign dot_out = dot_clk & dot_run;

  // Single-ended drive flags follow the enable bits (R8).
  assign pci_oe  = pci_en;
  assign pcif_oe = pcif_en;
  assign v66_oe  = v66_en;
  assign ref_oe  = ref_en;
  assign vch_oe  = vch_en;
  assign usb_oe  = usb_en;
  assign dot_oe  = dot_en;
endmodule

// File: rtl/clkstop_ctrl_chk.sv
`timescale 1ns/1ps
module clkstop_ctrl_chk #(
  parameter int N_CPU = 4
) (
  input logic             rst_n,
  input logic             cpu_clk,
  input logic             src_clk,
  input logic             v66_clk,
  input logic             pd_n,
  input logic             pd_active,
  input logic [N_CPU-1:0] cpu_en,
  input logic [N_CPU-1:0] cpu_run,
  input logic [N_CPU-1:0] cpu_t,
  input logic [N_CPU-1:0] cpu_c_oe,
  input logic             src_en,
  input logic             src_run,
  input logic             src_t,
  input logic             src_c,
  input logic             vch_a_on,
  input logic             vch_b_on
);
  // R1: power-down rises only after two successive low samples.
  a_r1_two_edge_qualify: assert property (@(negedge cpu_clk) disable iff (!rst_n)
    $rose(pd_active) |-> (!$past(pd_n) && !$past(pd_n, 2)));

  // R1: a high sample clears power-down at once.
  a_r1_release_clears: assert property (@(negedge cpu_clk) disable iff (!rst_n)
    $past(pd_n) |-> !pd_active);

  // R3: a stopped, enabled CPU pair shows true high with complement floating.
  generate
    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu_chk
      a_r3_cpu_park: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        (cpu_en[i] && !cpu_run[i]) |-> (cpu_t[i] && !cpu_c_oe[i]));
    end
  endgenerate

  // R4: a stopped SRC pair sits true high, complement low.
  a_r4_src_park: assert property (@(posedge src_clk) disable iff (!rst_n)
    (src_en && !src_run) |-> (src_t && !src_c));

  // R9: never both mux sources connected.
  a_r9_mux_exclusive: assert property (@(posedge v66_clk) disable iff (!rst_n)
    $onehot0({vch_a_on, vch_b_on}));
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.N_CPU(N_CPU)) u_chk (
  .rst_n     (rst_n),
  .cpu_clk   (cpu_clk),
  .src_clk   (src_clk),
  .v66_clk   (v66_clk),
  .pd_n      (pd_n),
  .pd_active (pd_active),
  .cpu_en    (cpu_en),
  .cpu_run   (cpu_run),
  .cpu_t     (cpu_t),
  .cpu_c_oe  (cpu_c_oe),
  .src_en    (src_en),
  .src_run   (src_run),
  .src_t     (src_t),
  .src_c     (src_c),
  .vch_a_on  (vch_a_on),
  .vch_b_on  (vch_b_on)
);

// File: tb/sim_clkstop_ctrl.sv
`timescale 1ns/100ps
module sim_clkstop_ctrl;
  localparam int CLK_PERIOD = 10;            // CPU source period, ns
  localparam int SRC_HALF   = 6;
  localparam int V66_HALF   = 8;
  localparam int PCI_HALF   = 16;
  localparam int USB_HALF   = 10;
  localparam int DOT_HALF   = 11;
  localparam int REF_HALF   = 35;
  localparam int NB         = 29;
  localparam int WATCHDOG   = 100000;

  // Output vector layout used by the bench.
  localparam logic [NB-1:0] M_ALL  = '1;
  localparam logic [NB-1:0] M_PCI  = 29'h000007F;
  localparam logic [NB-1:0] M_PCIF = 29'h0000380;
  localparam logic [NB-1:0] M_USB  = 29'h1 << 15;
  localparam logic [NB-1:0] M_CPUT = 29'hF << 19;
  localparam logic [NB-1:0] M_CPUC = 29'hF << 23;
  localparam logic [NB-1:0] M_SRCT = 29'h1 << 27;
  localparam logic [NB-1:0] M_SRCC = 29'h1 << 28;

  logic rst_n = 1'b0;
  logic cpu_clk = 0, src_clk = 0, v66_clk = 0, pci_clk = 0;
  logic usb_clk = 0, dot_clk = 0, ref_clk = 0;
  logic pd_n = 1'b1, pci_stop_n = 1'b1, sw_stop = 1'b0;
  logic [3:0] cpu_en = '1, cpu_pd_tri = '0;
  logic src_en = 1, src_pd_tri = 0, src_stp_en = 0, src_stp_tri = 0;
  logic [6:0] pci_en = '1;
  logic [2:0] pcif_en = '1, pcif_stp_en = '0;
  logic [3:0] v66_en = '1;
  logic vch_en = 1, vch_sel = 0, usb_en = 1, dot_en = 1;
  logic [1:0] ref_en = '1;

  logic [3:0] cpu_t, cpu_t_oe, cpu_c, cpu_c_oe;
  logic src_t, src_t_oe, src_c, src_c_oe;
  logic [6:0] pci_out, pci_oe;
  logic [2:0] pcif_out, pcif_oe;
  logic [3:0] v66_out, v66_oe;
  logic vch_out, vch_oe, usb_out, usb_oe, dot_out, dot_oe;
  logic [1:0] ref_out, ref_oe;

  clkstop_ctrl u0 (
    .rst_n(rst_n), .cpu_clk(cpu_clk), .src_clk(src_clk), .v66_clk(v66_clk),
    .pci_clk(pci_clk), .usb_clk(usb_clk), .dot_clk(dot_clk), .ref_clk(ref_clk),
    .pd_n(pd_n), .pci_stop_n(pci_stop_n), .sw_stop(sw_stop),
    .cpu_en(cpu_en), .cpu_pd_tri(cpu_pd_tri), .src_en(src_en),
    .src_pd_tri(src_pd_tri), .src_stp_en(src_stp_en), .src_stp_tri(src_stp_tri),
    .pci_en(pci_en), .pcif_en(pcif_en), .pcif_stp_en(pcif_stp_en),
    .v66_en(v66_en), .vch_en(vch_en), .vch_sel(vch_sel), .usb_en(usb_en),
    .dot_en(dot_en), .ref_en(ref_en),
    .cpu_t(cpu_t), .cpu_t_oe(cpu_t_oe), .cpu_c(cpu_c), .cpu_c_oe(cpu_c_oe),
    .src_t(src_t), .src_t_oe(src_t_oe), .src_c(src_c), .src_c_oe(src_c_oe),
    .pci_out(pci_out), .pci_oe(pci_oe), .pcif_out(pcif_out), .pcif_oe(pcif_oe),
    .v66_out(v66_out), .v66_oe(v66_oe), .vch_out(vch_out), .vch_oe(vch_oe),
    .usb_out(usb_out), .usb_oe(usb_oe), .dot_out(dot_out), .dot_oe(dot_oe),
    .ref_out(ref_out), .ref_oe(ref_oe)
  );

  wire [NB-1:0] all_clk = {src_c, src_t, cpu_c, cpu_t, ref_out, dot_out, usb_out,
                           vch_out, v66_out, pcif_out, pci_out};
  wire [NB-1:0] all_oe  = {src_c_oe, src_t_oe, cpu_c_oe, cpu_t_oe, ref_oe, dot_oe,
                           usb_oe, vch_oe, v66_oe, pcif_oe, pci_oe};

  always #(CLK_PERIOD/2) cpu_clk = ~cpu_clk;
  always #(SRC_HALF)     src_clk = ~src_clk;
  always #(V66_HALF)     v66_clk = ~v66_clk;
  always #(PCI_HALF)     pci_clk = ~pci_clk;
  always #(USB_HALF)     usb_clk = ~usb_clk;
  always #(DOT_HALF)     dot_clk = ~dot_clk;
  always #(REF_HALF)     ref_clk = ~ref_clk;

  int checks = 0, errors = 0, glitches = 0;
  bit done = 0;
  int hi_run  [NB];
  int last_hi [NB];
  logic [NB-1:0] seen_hi, seen_lo;

  // Shortest legal high time of each output line, from its source.
  function automatic int min_high(input int b);
    if (b <= 9)  return PCI_HALF;
    if (b <= 13) return V66_HALF;
    if (b == 14) return (V66_HALF < USB_HALF) ? V66_HALF : USB_HALF;
    if (b == 15) return USB_HALF;
    if (b == 16) return DOT_HALF;
    if (b <= 18) return REF_HALF;
    if (b <= 26) return CLK_PERIOD/2;
    return SRC_HALF;
  endfunction

  // Pulse-width monitor, sampling halfway between integer-ns edges.
  initial begin
    #0.5;
    forever begin
      for (int b = 0; b < NB; b++) begin
        if (!rst_n) hi_run[b] = 1000;
        else if (all_clk[b]) hi_run[b]++;
        else begin
          if (hi_run[b] > 0) begin
            if (hi_run[b] < min_high(b)) glitches++;
            last_hi[b] = hi_run[b];
          end
          hi_run[b] = 0;
        end
      end
      #1;
    end
  end

  task automatic check_vec(input string tag, input logic [NB-1:0] act,
                           input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Record which lines were seen high and low over n ns.
  task automatic observe(input int n);
    seen_hi = '0;
    seen_lo = '0;
    repeat (n) begin
      #1;
      seen_hi |= all_clk;
      seen_lo |= ~all_clk;
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic t_reset();
    // R11: parked pairs, quiet single-ended lines, CPU complements floating.
    check_vec("R11 reset levels", all_clk, M_CPUT | M_SRCT);
    check_vec("R11 reset drive", all_oe, M_ALL & ~M_CPUC);
  endtask

  task automatic t_run_all();
    observe(300);
    check_vec("R10 all outputs toggle", seen_hi & seen_lo, M_ALL);
    check_vec("R8 all driven", all_oe, M_ALL);
  endtask

  task automatic t_single_edge();
    // R1: low across one complement-clock edge only.
    @(negedge cpu_clk);
    #2.5 pd_n = 1'b0;
    #10  pd_n = 1'b1;
    observe(300);
    check_vec("R1 single edge ignored", seen_hi & seen_lo, M_ALL);
  endtask

  task automatic t_power_down();
    pd_n = 1'b0;
    #400;
    observe(200);
    check_vec("R2 outputs frozen in power-down", seen_hi & seen_lo, '0);
    check_vec("R2 R3 R4 parked levels", all_clk, M_CPUT | M_SRCT);
    check_vec("R3 R4 parked drive", all_oe, M_ALL & ~M_CPUC);
    pd_n = 1'b1;
    #400;
    observe(200);
    check_vec("R10 resume after power-down", seen_hi & seen_lo, M_ALL);
  endtask

  task automatic t_power_down_float();
    cpu_pd_tri = 4'b0101;
    src_pd_tri = 1'b1;
    pd_n = 1'b0;
    #400;
    check_vec("R3 R4 float bits in power-down", all_oe,
              M_ALL & ~M_CPUC & ~(29'h1 << 19) & ~(29'h1 << 21) & ~M_SRCT & ~M_SRCC);
    pd_n = 1'b1;
    #400;
    cpu_pd_tri = '0;
    src_pd_tri = 1'b0;
    check_vec("R3 drive restored after release", all_oe, M_ALL);
  endtask

  task automatic t_pin_stop();
    logic [NB-1:0] stopped;
    stopped = M_PCI | (29'h1 << 7) | (29'h1 << 9) | M_SRCT | M_SRCC;
    pcif_stp_en = 3'b101;
    src_stp_en  = 1'b1;
    pci_stop_n  = 1'b0;
    #300;
    observe(200);
    check_vec("R5 pin stop toggling set", seen_hi & seen_lo, M_ALL & ~stopped);
    check_vec("R5 pin stop parked levels", all_clk & stopped, M_SRCT);
    check_vec("R7 src driven under stop", all_oe, M_ALL);
    src_stp_tri = 1'b1;
    #50;
    check_vec("R7 src floats under stop", all_oe, M_ALL & ~(M_SRCT | M_SRCC));
    pci_stop_n = 1'b1;
    #300;
    src_stp_tri = 1'b0;
    observe(200);
    check_vec("R10 resume after pin stop", seen_hi & seen_lo, M_ALL);
    pcif_stp_en = '0;
    src_stp_en  = 1'b0;
  endtask

  task automatic t_sw_stop();
    sw_stop = 1'b1;
    #300;
    observe(200);
    check_vec("R6 software stop toggling set", seen_hi & seen_lo, M_ALL & ~M_PCI);
    check_vec("R6 software stop parks bus low", all_clk & M_PCI, '0);
    sw_stop = 1'b0;
    #300;
    observe(200);
    check_vec("R6 resume after software stop", seen_hi & seen_lo, M_ALL);
  endtask

  task automatic t_enables();
    pci_en[3] = 1'b0;
    cpu_en[2] = 1'b0;
    src_en    = 1'b0;
    usb_en    = 1'b0;
    observe(200);
    check_vec("R8 disabled lines undriven", all_oe,
              M_ALL & ~(29'h1 << 3) & ~(29'h1 << 21) & ~(29'h1 << 25) &
              ~M_SRCT & ~M_SRCC & ~M_USB);
    check_vec("R8 clocks still generated", seen_hi & seen_lo, M_ALL);
    pci_en = '1; cpu_en = '1; src_en = 1'b1; usb_en = 1'b1;
  endtask

  task automatic t_vch();
    vch_sel = 1'b1;
    #300;
    check_int("R9 select 48 MHz high time", last_hi[14], USB_HALF);
    vch_sel = 1'b0;
    #300;
    check_int("R9 select 66 MHz high time", last_hi[14], V66_HALF);
  endtask

  initial begin
    #0.5;
    #50;
    t_reset();
    #50 rst_n = 1'b1;
    #400;
    t_run_all();
    t_single_edge();
    t_power_down();
    t_power_down_float();
    t_pin_stop();
    t_sw_stop();
    t_enables();
    t_vch();
    // R2 R9 R10: no high pulse shorter than its source's high time.
    check_int("R10 short high pulses", glitches, 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(WATCHDOG);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule